// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder for a Nonvolatile SRAM Port

This block sits beside an asynchronous SRAM-style port and watches its control and address lines, sampled in the system clock domain. It searches the access stream for a fixed series of six reads. The first five reads form an unlock prefix. The address of the sixth read chooses the command: save the SRAM image into nonvolatile cells (store), or load the image back (recall). Any other access that falls inside the series cancels it.

When a command is accepted, the block pulses a one-cycle start strobe and holds a busy flag for a parameter-set number of clock cycles. The busy flag also serves as the disable for the memory port. A recall has two phases: the SRAM is cleared first, then the nonvolatile data is loaded. The block reports which phase is running so the array controller can sequence the work. Accesses that arrive while the block is busy are ignored.

Top module: `nvcmd_seq_decoder`

## Requirements
- R1: The five prefix reads must hit 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F in exactly that order. Any other order produces no command.
- R2: After a complete prefix, a sixth read at 0x8FC0 pulses `store_start` for one cycle and a sixth read at 0x4C63 pulses `recall_start` for one cycle. A sixth read at any other address starts nothing.
- R3: A read at an address that does not match the expected step cancels the series. The remaining steps then issue no command.
- R4: A write cycle (`bus_ce_n` low, `bus_we_n` low) cancels the series and never counts as a step, even when its address matches.
- R5: A read cycle is `bus_ce_n` low with `bus_we_n` high. It counts once, on the first clock edge where it is seen active, and again only if the address changes while chip enable stays low. A read held over several cycles therefore counts once, and output enable takes no part in the decision.
- R6: `busy` and `port_disable` rise together with the start strobe. They stay high for exactly STORE_CYC cycles after a store and RECALL_CYC cycles after a recall.
- R7: During a recall, `recall_clear` is high for the first CLEAR_CYC busy cycles and `recall_load` is high for the remaining RECALL_CYC-CLEAR_CYC cycles. The two are never high together, and neither is high during a store.
- R8: Reads and writes sampled while `busy` is high are ignored. They neither advance nor cancel the series, and no command can start until `busy` has fallen.
- R9: A mismatching read at 0x4E38 is itself taken as the first step of a new series.
- R10: After reset the block is idle: `busy`, `port_disable`, both start strobes and both recall phase outputs are low, and the series is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Port chip enable, active low |
| bus_we_n | input | 1 | Port write enable, active low |
| bus_addr | input | 16 | Port address |
| store_start | output | 1 | One-cycle pulse when a store command is accepted |
| recall_start | output | 1 | One-cycle pulse when a recall command is accepted |
| busy | output | 1 | A store or recall is running |
| port_disable | output | 1 | Disables port input and output while busy |
| recall_clear | output | 1 | Recall phase 1: clear the SRAM |
| recall_load | output | 1 | Recall phase 2: load the nonvolatile data |

## Verification
Each access is judged on the clock edge that samples it. The start strobe, `busy` and `port_disable` are therefore visible one register later: the bench drives on falling edges, and after the sampling edge it reads them at the following falling edge, as the task that issues the sixth read returns. From that falling edge the bench counts busy and phase cycles until `busy` drops, and compares the totals with the cycle parameters. Commands that must not happen are checked through strobe counters, which are updated at rising edges and compared only after the bus has been idle for several cycles and `busy` is low.

// File: rtl/nvcmd_pkg.sv
// Package: shared constants and the key lookup for the unlock-sequence decoder.
// Assumes a 16-bit port address; the key values define the command protocol.
package nvcmd_pkg;
    localparam int ADDR_W  = 16;
    localparam int KEY_LEN = 5;   // number of prefix reads before the selector read
    localparam logic [ADDR_W-1:0] STORE_SEL  = 16'h8FC0;
    localparam logic [ADDR_W-1:0] RECALL_SEL = 16'h4C63;

    // Address expected at prefix step idx (0-based); order is part of the protocol.
    function automatic logic [ADDR_W-1:0] prefix_key(input logic [2:0] idx);
        case (idx)
            3'd0:    prefix_key = 16'h4E38;
            3'd1:    prefix_key = 16'hB1C7;
            3'd2:    prefix_key = 16'h83E0;
            3'd3:    prefix_key = 16'h7C1F;
            3'd4:    prefix_key = 16'h703F;
            default: prefix_key = '0;
        endcase
    endfunction
endpackage

// File: rtl/nvcmd_access_detect.sv
// Access detector: turns sampled port levels into single-cycle read and write
// events. An event fires when the cycle type first becomes active or when the
// address moves while it stays active, so a held access is counted once.
// Assumes the port inputs are already synchronous to clk.
module nvcmd_access_detect
    import nvcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_evt,
    output logic              wr_evt
);
    logic              rd_prev, wr_prev;
    logic [ADDR_W-1:0] addr_prev;
    logic              rd_now, wr_now, addr_moved;

    // Classify the current sample and detect a fresh access.
    always_comb begin
        rd_now     = !ce_n && we_n;
        wr_now     = !ce_n && !we_n;
        addr_moved = (addr != addr_prev);
        rd_evt     = rd_now && (!rd_prev || addr_moved);
        wr_evt     = wr_now && (!wr_prev || addr_moved);
    end

    // Remember the previous sample for edge and address-change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev   <= 1'b0;
            wr_prev   <= 1'b0;
            addr_prev <= '0;
        end else begin
            rd_prev   <= rd_now;
            wr_prev   <= wr_now;
            addr_prev <= addr;
        end
    end

    assert_rd_wr_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_evt && wr_evt));
    assert_held_read_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !ce_n && we_n) |=> ((!ce_n && we_n && $stable(addr)) |-> !rd_evt));
endmodule

// File: rtl/nvcmd_seq_match.sv
// Sequence matcher: tracks progress through the five prefix reads and decodes
// the selector read. Any mismatching read or any write cancels the progress;
// a mismatching read at the first key restarts the series at step one.
// Events are ignored while hold is high. Hits are combinational, for one cycle.
module nvcmd_seq_match
    import nvcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_evt,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hold,
    output logic              store_hit,
    output logic              recall_hit
);
    localparam logic [2:0] LAST_STEP = 3'(KEY_LEN);

    logic [2:0]       step, step_nx;
    logic [KEY_LEN:0] key_hit;   // key_hit[KEY_LEN] is a zero pad for the selector step

    // One comparator per prefix key.
    genvar gi;
    generate
        for (gi = 0; gi < KEY_LEN; gi++) begin : g_key
            assign key_hit[gi] = (addr == prefix_key(3'(gi)));
        end
    endgenerate
    assign key_hit[KEY_LEN] = 1'b0;

    // Next-step and hit decode.
    always_comb begin
        step_nx    = step;
        store_hit  = 1'b0;
        recall_hit = 1'b0;
        if (!hold) begin
            if (wr_evt) begin
                step_nx = 3'd0;
            end else if (rd_evt) begin
                if (step == LAST_STEP) begin
                    store_hit  = (addr == STORE_SEL);
                    recall_hit = (addr == RECALL_SEL);
                    if (store_hit || recall_hit) step_nx = 3'd0;
                    else                         step_nx = key_hit[0] ? 3'd1 : 3'd0;
                end else if (key_hit[step]) begin
                    step_nx = step + 3'd1;
                end else begin
                    step_nx = key_hit[0] ? 3'd1 : 3'd0;
                end
            end
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= 3'd0;
        else        step <= step_nx;
    end

    assert_write_cancels_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !hold) |=> (step == 3'd0));
    assert_hit_after_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (store_hit || recall_hit) |-> (step == LAST_STEP));
    assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(step));
    assert_step_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST_STEP);
endmodule

// File: rtl/nvcmd_busy_timer.sv
// Busy timer: on a store or recall hit, emits a one-cycle start strobe and
// holds busy for the command's duration in cycles. For a recall it splits the
// busy window into a clear phase followed by a load phase.
// Assumes 1 <= CLEAR_CYC < RECALL_CYC and STORE_CYC >= 1.
module nvcmd_busy_timer #(
    parameter int STORE_CYC  = 24,
    parameter int RECALL_CYC = 16,
    parameter int CLEAR_CYC  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_hit,
    input  logic recall_hit,
    output logic busy,
    output logic store_start,
    output logic recall_start,
    output logic recall_clear,
    output logic recall_load
);
    localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] STORE_LEN  = CW'(STORE_CYC);
    localparam logic [CW-1:0] RECALL_LEN = CW'(RECALL_CYC);
    localparam logic [CW-1:0] CLEAR_LEN  = CW'(CLEAR_CYC);

    logic          busy_q, is_recall, store_q, recall_q;
    logic [CW-1:0] elapsed, dur_q;

    // Launch, count and end the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            is_recall <= 1'b0;
            store_q   <= 1'b0;
            recall_q  <= 1'b0;
            elapsed   <= '0;
            dur_q     <= '0;
        end else begin
            store_q  <= 1'b0;
            recall_q <= 1'b0;
            if (busy_q) begin
                if (elapsed == dur_q - CW'(1)) busy_q  <= 1'b0;
                else                           elapsed <= elapsed + CW'(1);
            end else if (store_hit || recall_hit) begin
                busy_q    <= 1'b1;
                elapsed   <= '0;
                is_recall <= recall_hit;
                dur_q     <= recall_hit ? RECALL_LEN : STORE_LEN;
                store_q   <= store_hit;
                recall_q  <= recall_hit;
            end
        end
    end

    // Output decode, including the recall phase split.
    always_comb begin
        busy         = busy_q;
        store_start  = store_q;
        recall_start = recall_q;
        recall_clear = busy_q && is_recall && (elapsed < CLEAR_LEN);
        recall_load  = busy_q && is_recall && (elapsed >= CLEAR_LEN);
    end

    assert_start_raises_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (store_start || recall_start) |-> (busy && elapsed == '0));
    assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (elapsed < dur_q));
    assert_no_start_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(store_start || recall_start));
    assert_phases_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(recall_clear && recall_load));
    assert_clear_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start |-> recall_clear);
endmodule

// File: rtl/nvcmd_seq_decoder.sv
// Top: unlock-sequence command decoder. Watches the port, matches the six-read
// series and runs the store/recall busy window that disables the port.
// Assumes synchronous port inputs; durations are in clk cycles.
module nvcmd_seq_decoder #(
    parameter int STORE_CYC  = 24,
    parameter int RECALL_CYC = 16,
    parameter int CLEAR_CYC  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_ce_n,
    input  logic        bus_we_n,
    input  logic [15:0] bus_addr,
    output logic        store_start,
    output logic        recall_start,
    output logic        busy,
    output logic        port_disable,
    output logic        recall_clear,
    output logic        recall_load
);
    logic rd_evt, wr_evt, store_hit, recall_hit;

    nvcmd_access_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (bus_ce_n),
        .we_n   (bus_we_n),
        .addr   (bus_addr),
        .rd_evt (rd_evt),
        .wr_evt (wr_evt)
    );

    nvcmd_seq_match u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_evt     (rd_evt),
        .wr_evt     (wr_evt),
        .addr       (bus_addr),
        .hold       (busy),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    nvcmd_busy_timer #(
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC),
        .CLEAR_CYC  (CLEAR_CYC)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .store_hit    (store_hit),
        .recall_hit   (recall_hit),
        .busy         (busy),
        .store_start  (store_start),
        .recall_start (recall_start),
        .recall_clear (recall_clear),
        .recall_load  (recall_load)
    );

    // The port stays disabled for the whole busy window.
    assign port_disable = busy;

    assert_disable_tracks_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (store_start || recall_start));
endmodule

// File: tb/tb_nvcmd_seq_decoder.sv
module tb_nvcmd_seq_decoder;
    localparam int ST = 24, RC = 16, CL = 5;
    localparam logic [15:0] K0 = 16'h4E38, K1 = 16'hB1C7, K2 = 16'h83E0,
                            K3 = 16'h7C1F, K4 = 16'h703F;
    localparam logic [15:0] SSEL = 16'h8FC0, RSEL = 16'h4C63;

    logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1;
    logic [15:0] addr = '0;
    logic store_start, recall_start, busy, port_disable, recall_clear, recall_load;
    int n_chk = 0, n_bad = 0, n_store = 0, n_recall = 0;
    bit done = 0;
    logic [15:0] keys [5];

    nvcmd_seq_decoder #(.STORE_CYC(ST), .RECALL_CYC(RC), .CLEAR_CYC(CL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_addr(addr),
        .store_start(store_start), .recall_start(recall_start), .busy(busy),
        .port_disable(port_disable), .recall_clear(recall_clear), .recall_load(recall_load));

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (store_start)  n_store++;
        if (recall_start) n_recall++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk); ce_n = 0; we_n = 1; addr = a;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic wr(input logic [15:0] a);
        @(negedge clk); ce_n = 0; we_n = 0; addr = a;
        @(negedge clk); ce_n = 1; we_n = 1;
    endtask

    task automatic prefix();
        for (int i = 0; i < 5; i++) rd(keys[i]);
    endtask

    task automatic settle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Measure busy, disable and phase lengths from the current falling edge.
    task automatic measure(output int nb, output int nd, output int nc, output int nl);
        nb = 0; nd = 0; nc = 0; nl = 0;
        while (busy) begin
            nb++;
            if (port_disable) nd++;
            if (recall_clear) nc++;
            if (recall_load)  nl++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int nb, nd, nc, nl, s0, r0;
        keys[0] = K0; keys[1] = K1; keys[2] = K2; keys[3] = K3; keys[4] = K4;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: idle after reset
        check({busy, port_disable, store_start, recall_start, recall_clear, recall_load} == 6'b0,
              "R10 reset outputs", int'(busy), 0);

        // R2/R6: store command
        prefix(); rd(SSEL);
        check(store_start == 1 && recall_start == 0, "R2 store strobe", int'(store_start), 1);
        measure(nb, nd, nc, nl);
        check(nb == ST, "R6 store busy length", nb, ST);
        check(nd == ST, "R6 store port_disable length", nd, ST);
        check(nc + nl == 0, "R7 no recall phases in store", nc + nl, 0);
        settle();
        check(n_store == 1, "R2 one store pulse", n_store, 1);

        // R2/R7: recall command
        prefix(); rd(RSEL);
        check(recall_start == 1 && store_start == 0, "R2 recall strobe", int'(recall_start), 1);
        measure(nb, nd, nc, nl);
        check(nb == RC, "R6 recall busy length", nb, RC);
        check(nc == CL, "R7 clear phase length", nc, CL);
        check(nl == RC - CL, "R7 load phase length", nl, RC - CL);
        settle();
        check(n_recall == 1, "R2 one recall pulse", n_recall, 1);

        // R2: other selector addresses start nothing
        for (int j = 0; j < 4; j++) begin
            logic [15:0] bad;
            bad = (j == 0) ? 16'h0000 : (j == 1) ? (SSEL ^ 16'h0001) :
                  (j == 2) ? (RSEL ^ 16'h8000) : K4;
            s0 = n_store; r0 = n_recall;
            prefix(); rd(bad); settle();
            check(n_store == s0 && n_recall == r0 && !busy, "R2 bad selector ignored",
                  n_store + n_recall - s0 - r0, 0);
        end

        // R3/R4: abort sweep at every step position, by stray read and by write
        for (int kind = 0; kind < 2; kind++) begin
            for (int p = 1; p <= 5; p++) begin
                logic [15:0] hit_a;
                s0 = n_store;
                for (int i = 0; i < p; i++) rd(keys[i]);
                hit_a = (p == 5) ? SSEL : keys[p];
                if (kind == 0) rd(hit_a ^ 16'h0100);
                else           wr(hit_a);
                for (int i = p; i < 5; i++) rd(keys[i]);
                rd(SSEL); settle();
                if (kind == 0) check(n_store == s0, "R3 stray read aborts", n_store - s0, 0);
                else           check(n_store == s0, "R4 write aborts", n_store - s0, 0);
            end
        end
        // R4: after a write abort a clean series still works
        wr(K0); prefix(); rd(SSEL);
        check(store_start == 1, "R4 recovery after write", int'(store_start), 1);
        settle();

        // R1: wrong order
        s0 = n_store;
        rd(K0); rd(K2); rd(K1); rd(K3); rd(K4); rd(SSEL); settle();
        check(n_store == s0, "R1 swapped order rejected", n_store - s0, 0);

        // R9: mismatch at first key restarts
        rd(K0); rd(K1); rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(SSEL);
        check(store_start == 1, "R9 restart on first key", int'(store_start), 1);
        settle();

        // R5: held read counted once
        rd(K0);
        @(negedge clk); ce_n = 0; we_n = 1; addr = K1;
        repeat (3) @(negedge clk);
        ce_n = 1;
        rd(K2); rd(K3); rd(K4); rd(SSEL);
        check(store_start == 1, "R5 held read counted once", int'(store_start), 1);
        settle();

        // R5: chip enable held low, address changes mark each step
        @(negedge clk); ce_n = 0; we_n = 1; addr = K0;
        for (int i = 1; i < 5; i++) begin @(negedge clk); addr = keys[i]; end
        @(negedge clk); addr = RSEL;
        @(negedge clk); ce_n = 1;
        check(recall_start == 1, "R5 address-change framing", int'(recall_start), 1);
        settle();

        // R8: full recall series while a store is busy is ignored
        r0 = n_recall;
        prefix(); rd(SSEL);
        prefix(); rd(RSEL);
        check(busy == 1, "R8 still busy during ignored series", int'(busy), 1);
        settle();
        check(n_recall == r0, "R8 accesses during busy ignored", n_recall - r0, 0);
        prefix(); rd(RSEL);
        check(recall_start == 1, "R8 normal after busy", int'(recall_start), 1);
        settle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule